// File: doc/BRIEF.md
# Randomized-Polarity Parity Self-Check Engine

This engine runs a built-in trust check over an array of logic cells under test. A start pulse launches a binary pattern counter, which drives every combination of the cells' input bits, one combination per clock. The cell outputs return to the engine, which registers them and folds them into parity groups. Each group is defined by a programmable membership mask over the cells, so the grouping can be an arbitrary random subset. Giving each cell a place in two independent groupings forms a two-dimensional code. Cells that the mapped design does not use are still placed in groups, so logic added in spare cells changes a parity bit.

For every pattern the engine holds a secret expected-polarity word, with one even or odd bit per group. A group passes when the XOR of its member outputs equals its polarity bit. This is the same as its XOR (even) or XNOR (odd) parity being zero. A tamper that forces the analyzer's inputs cannot guess the expected vector. The first pattern whose parity vector differs is recorded and a sticky fail flag is raised. A done flag marks the end of the sweep. Masks and polarities are written through a small write port while the engine is idle.

Top module: `sc_engine`

## Requirements
- R1: After synchronous reset, busy, done and fail are 0 and pat_out is 0.
- R2: A start pulse accepted while idle makes pat_out equal 0 in the next cycle. pat_out then rises by one each cycle up to 2^IN_W-1, and busy stays high throughout.
- R3: The cycle after pat_out reaches 2^IN_W-1 is a check cycle: busy stays 1, pat_out holds and done stays 0. In the cycle after that, busy is 0 and done is 1. done stays 1 until the next accepted start.
- R4: The parity bit of group g for a pattern is the XOR of the bits of cell_resp, sampled while that pattern was on pat_out, whose position c has bit c of group g's mask set.
- R5: Bit g of the polarity word for pattern p gives the expected parity of group g (0 = even, 1 = odd). Pattern p passes only when all group parity bits equal their polarity bits.
- R6: fail rises by the done cycle if any pattern fails. fail_idx then holds the lowest failing pattern index, and both stay unchanged until the next accepted start.
- R7: An accepted start clears fail, fail_idx and done.
- R8: A write with cfg_we=1 and cfg_sel=0 sets the mask of group cfg_idx to cfg_data[CELLS-1:0]. A write with cfg_sel=1 sets the polarity word of pattern cfg_idx to cfg_data[GROUPS-1:0]. Writes made while busy is 1 are ignored.
- R9: A start pulse while busy has no effect on the running sweep.
- R10: A cell whose bit is clear in every group mask has no effect on the result.
- R11: A change in a cell that no design logic drives (a spare cell, here held at 0) is caught when that cell is in the masks.
- R12: Two faulty cells that share a group in one grouping are still caught through the second grouping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a sweep (taken only when idle) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = group mask, 1 = polarity word |
| cfg_idx | input | IDX_W (4) | Group or pattern index |
| cfg_data | input | CFG_W (16) | Write data |
| cell_resp | input | CELLS (16) | Outputs returned by the cells under test |
| pat_out | output | IN_W (4) | Test vector driven to the cells |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep finished (sticky) |
| fail | output | 1 | Mismatch seen (sticky) |
| fail_idx | output | IN_W (4) | First mismatching pattern |

## Verification
The cells are modelled as a fixed function of the pattern, with one spare cell tied to 0. The polarity table is programmed from that function, so a clean sweep must pass. Single-cell faults are injected at the first, a middle and the last pattern, which checks the delayed capture index and the boundary. Faults at two patterns in one sweep check that the lowest index is kept. A spare-cell fault and a pair of faults sharing a row group check the coverage of the two-dimensional code. A fault on a cell removed from every mask must pass. A sweep that receives a polarity write and a start pulse in mid-run must run on undisturbed.

// File: rtl/sc_pkg.sv
package sc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_CHECK = 2'd2
    } sc_state_e;

    function automatic int sc_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int sc_clog2(input int v);
        int r = 0;
        while ((1 << r) < v) r++;
        return (r == 0) ? 1 : r;
    endfunction

endpackage

// File: rtl/sc_sequencer.sv
module sc_sequencer
    import sc_pkg::*;
#(
    parameter int IN_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    output logic [IN_W-1:0] pat,
    output sc_state_e       state,
    output logic            accept,
    output logic            done
);
    localparam logic [IN_W-1:0] LAST = {IN_W{1'b1}};

    assign accept = start && (state == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pat   <= '0;
            done  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    state <= ST_RUN;
                    pat   <= '0;
                    done  <= 1'b0;
                end
                ST_RUN: begin
                    if (pat == LAST) state <= ST_CHECK;
                    else             pat   <= pat + IN_W'(1);
                end
                ST_CHECK: begin
                    state <= ST_IDLE;
                    done  <= 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R2: counter steps by one while sweeping
    a_r2_step: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && pat != LAST) |=> (pat == IN_W'($past(pat) + IN_W'(1))));

    // R3: done only rises out of the check cycle
    a_r3_done_after_check: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(state) == ST_CHECK) && (state == ST_IDLE));

    // R9: a start while running does not restart the counter
    a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && pat != LAST && start) |=> (state == ST_RUN && pat != '0));

endmodule

// File: rtl/sc_cfg_store.sv
module sc_cfg_store #(
    parameter int IN_W   = 4,
    parameter int CELLS  = 16,
    parameter int GROUPS = 8,
    parameter int IDX_W  = 4,
    parameter int CFG_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          busy,
    input  logic                          we,
    input  logic                          sel,
    input  logic [IDX_W-1:0]              idx,
    input  logic [CFG_W-1:0]              data,
    input  logic [IN_W-1:0]               rd_pat,
    output logic [GROUPS-1:0][CELLS-1:0]  masks,
    output logic [GROUPS-1:0]             pol_rd
);
    localparam int PATS = 1 << IN_W;

    logic [PATS-1:0][GROUPS-1:0] pol;
    logic wr_ok;

    assign wr_ok  = we && !busy;
    assign pol_rd = pol[rd_pat];

    for (genvar g = 0; g < GROUPS; g++) begin : g_mask
        always_ff @(posedge clk) begin
            if (rst)                                       masks[g] <= '0;
            else if (wr_ok && !sel && int'(idx) == g)      masks[g] <= data[CELLS-1:0];
        end
    end

    for (genvar p = 0; p < PATS; p++) begin : g_pol
        always_ff @(posedge clk) begin
            if (rst)                                       pol[p] <= '0;
            else if (wr_ok && sel && int'(idx) == p)       pol[p] <= data[GROUPS-1:0];
        end
    end

    // R8: configuration frozen while a sweep runs
    a_r8_frozen_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(masks) && $stable(pol)));

endmodule

// File: rtl/sc_parity_fold.sv
module sc_parity_fold #(
    parameter int CELLS  = 16,
    parameter int GROUPS = 8
) (
    input  logic [GROUPS-1:0][CELLS-1:0] masks,
    input  logic [CELLS-1:0]             resp,
    output logic [GROUPS-1:0]            par
);
    for (genvar g = 0; g < GROUPS; g++) begin : g_fold
        assign par[g] = ^(resp & masks[g]);
    end
endmodule

// File: rtl/sc_analyzer.sv
module sc_analyzer #(
    parameter int IN_W   = 4,
    parameter int GROUPS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              cap_v,
    input  logic [IN_W-1:0]   cap_idx,
    input  logic [GROUPS-1:0] par,
    input  logic [GROUPS-1:0] expect_v,
    output logic              fail,
    output logic [IN_W-1:0]   fail_idx
);
    logic miss;
    assign miss = cap_v && (par != expect_v);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            fail     <= 1'b0;
            fail_idx <= '0;
        end else if (miss && !fail) begin
            fail     <= 1'b1;
            fail_idx <= cap_idx;
        end
    end

    // R6: failure and its index are held
    a_r6_fail_sticky: assert property (@(posedge clk) disable iff (rst)
        (fail && !clr) |=> (fail && $stable(fail_idx)));

    // R7: an accepted start clears the verdict
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!fail && fail_idx == '0));

endmodule

// File: rtl/sc_engine.sv
module sc_engine
    import sc_pkg::*;
#(
    parameter int IN_W   = 4,
    parameter int CELLS  = 16,
    parameter int GROUPS = 8,
    parameter int IDX_W  = sc_max(sc_clog2(GROUPS), IN_W),
    parameter int CFG_W  = sc_max(CELLS, GROUPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic [CELLS-1:0] cell_resp,
    output logic [IN_W-1:0]  pat_out,
    output logic             busy,
    output logic             done,
    output logic             fail,
    output logic [IN_W-1:0]  fail_idx
);
    typedef struct packed {
        logic             v;
        logic [IN_W-1:0]  idx;
        logic [CELLS-1:0] resp;
    } capture_t;

    sc_state_e                   state;
    logic                        accept;
    capture_t                    cap;
    logic [GROUPS-1:0][CELLS-1:0] masks;
    logic [GROUPS-1:0]           pol_rd;
    logic [GROUPS-1:0]           par;

    sc_sequencer #(.IN_W(IN_W)) u_seq (
        .clk(clk), .rst(rst), .start(start),
        .pat(pat_out), .state(state), .accept(accept), .done(done)
    );

    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap <= '0;
        end else begin
            cap.v    <= (state == ST_RUN);
            cap.idx  <= pat_out;
            cap.resp <= cell_resp;
        end
    end

    sc_cfg_store #(
        .IN_W(IN_W), .CELLS(CELLS), .GROUPS(GROUPS), .IDX_W(IDX_W), .CFG_W(CFG_W)
    ) u_cfg (
        .clk(clk), .rst(rst), .busy(busy), .we(cfg_we), .sel(cfg_sel),
        .idx(cfg_idx), .data(cfg_data), .rd_pat(cap.idx),
        .masks(masks), .pol_rd(pol_rd)
    );

    sc_parity_fold #(.CELLS(CELLS), .GROUPS(GROUPS)) u_fold (
        .masks(masks), .resp(cap.resp), .par(par)
    );

    sc_analyzer #(.IN_W(IN_W), .GROUPS(GROUPS)) u_ora (
        .clk(clk), .rst(rst), .clr(accept), .cap_v(cap.v), .cap_idx(cap.idx),
        .par(par), .expect_v(pol_rd), .fail(fail), .fail_idx(fail_idx)
    );

    // R1: idle engine reports nothing
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (!busy && !done) |-> !fail);

    // R5: capture is only valid during or right after the sweep
    a_r5_capture_in_sweep: assert property (@(posedge clk) disable iff (rst)
        cap.v |-> busy);

endmodule

// File: tb/sc_engine_test.sv
module sc_engine_test;
    localparam int PERIOD = 10;
    localparam int IN_W = 4, CELLS = 16, GROUPS = 8, IDX_W = 4, CFG_W = 16;
    localparam int PATS = 1 << IN_W;

    logic clk = 0, rst = 1, start = 0, cfg_we = 0, cfg_sel = 0;
    logic [IDX_W-1:0] cfg_idx = '0;
    logic [CFG_W-1:0] cfg_data = '0;
    logic [CELLS-1:0] cell_resp;
    logic [IN_W-1:0]  pat_out, fail_idx;
    logic busy, done, fail;

    int checks = 0, errors = 0;
    logic [CELLS-1:0]  bmask [GROUPS];
    logic [GROUPS-1:0] bpol  [PATS];
    logic [CELLS-1:0]  tm    [PATS];

    always #(PERIOD/2) clk = ~clk;

    sc_engine uut (
        .clk(clk), .rst(rst), .start(start), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_idx(cfg_idx), .cfg_data(cfg_data), .cell_resp(cell_resp),
        .pat_out(pat_out), .busy(busy), .done(done), .fail(fail), .fail_idx(fail_idx)
    );

    // cells under test: fixed function of the pattern, cell 15 is a spare tied to 0
    function automatic logic [CELLS-1:0] good(input int p);
        logic [CELLS-1:0] r = '0;
        for (int c = 0; c < CELLS - 1; c++)
            r[c] = (^(4'(p) & 4'(c + 1))) ^ c[0];
        return r;
    endfunction

    assign cell_resp = good(int'(pat_out)) ^ tm[pat_out];

    function automatic logic [GROUPS-1:0] parity_vec(input logic [CELLS-1:0] r);
        logic [GROUPS-1:0] v;
        for (int g = 0; g < GROUPS; g++) v[g] = ^(r & bmask[g]);
        return v;
    endfunction

    function automatic int first_fail();
        for (int p = 0; p < PATS; p++)
            if (parity_vec(good(p) ^ tm[p]) != bpol[p]) return p;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_write(input bit sel, input int idx, input logic [CFG_W-1:0] d);
        cfg_we = 1; cfg_sel = sel; cfg_idx = IDX_W'(idx); cfg_data = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    // two random-looking groupings: groups 0..3 and groups 4..7
    task automatic load_masks(input int drop_cell);
        for (int g = 0; g < GROUPS; g++) bmask[g] = '0;
        for (int c = 0; c < CELLS; c++) begin
            if (c != drop_cell) begin
                bmask[(c * 3 + 1) % 4][c]       = 1'b1;
                bmask[4 + ((c + c / 4) % 4)][c] = 1'b1;
            end
        end
        for (int g = 0; g < GROUPS; g++) cfg_write(1'b0, g, CFG_W'(bmask[g]));
        for (int p = 0; p < PATS; p++) begin
            bpol[p] = parity_vec(good(p));
            cfg_write(1'b1, p, CFG_W'(bpol[p]));
        end
    endtask

    task automatic clear_tamper();
        for (int p = 0; p < PATS; p++) tm[p] = '0;
    endtask

    // sweep with reference model checked every clock; wr_at / st_at inject mid-run events
    task automatic run(input string req, input int wr_at, input int st_at);
        int exp_ff = first_fail();
        start = 1;
        @(negedge clk);
        start = 0;
        for (int k = 0; k < PATS; k++) begin
            chk(pat_out == IN_W'(k), "R2", "pat_out", int'(pat_out), k);
            chk(busy == 1'b1 && done == 1'b0, "R2", "busy/done in sweep",
                int'({busy, done}), 2);
            if (k == wr_at) begin
                cfg_we = 1; cfg_sel = 1; cfg_idx = 4'd4; cfg_data = CFG_W'(~bpol[4]);
            end
            if (k == st_at) start = 1;
            @(negedge clk);
            cfg_we = 0; start = 0;
        end
        chk(busy && !done && pat_out == IN_W'(PATS - 1), "R3", "check cycle",
            int'({busy, done}), 2);
        @(negedge clk);
        chk(!busy && done, "R3", "done cycle", int'({busy, done}), 1);
        chk(fail == (exp_ff >= 0), {req, " verdict"}, "fail", int'(fail), int'(exp_ff >= 0));
        if (exp_ff >= 0)
            chk(fail_idx == IN_W'(exp_ff), {req, " R6"}, "fail_idx", int'(fail_idx), exp_ff);
        @(negedge clk);
        chk(done && fail == (exp_ff >= 0), "R3 R6", "held after done", int'({done, fail}),
            int'({1'b1, exp_ff >= 0}));
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end

    initial begin
        clear_tamper();
        repeat (3) @(negedge clk);
        rst = 0;
        chk(!busy && !done && !fail && pat_out == '0, "R1", "reset state",
            int'({busy, done, fail}), 0);

        load_masks(-1);
        run("R4 R5 clean", -1, -1);

        tm[9][5] = 1'b1;                       // single fault, middle pattern
        run("R5 R7 mid fault", -1, -1);
        chk(fail_idx == 4'd9, "R6", "mid index", int'(fail_idx), 9);

        clear_tamper();
        run("R7 cleared", -1, -1);
        chk(!fail, "R7", "fail cleared", int'(fail), 0);

        tm[3][2] = 1'b1; tm[12][8] = 1'b1;     // two faulty patterns
        run("R6 first of two", -1, -1);
        chk(fail_idx == 4'd3, "R6", "lowest index kept", int'(fail_idx), 3);

        clear_tamper(); tm[PATS-1][0] = 1'b1;  // last pattern
        run("R6 last pattern", -1, -1);
        chk(fail_idx == 4'(PATS - 1), "R6", "last index", int'(fail_idx), PATS - 1);

        clear_tamper(); tm[0][15] = 1'b1;      // spare cell disturbed at first pattern
        run("R11 spare cell", -1, -1);
        chk(fail && fail_idx == '0, "R11", "spare cell caught", int'(fail), 1);

        clear_tamper(); tm[6][0] = 1'b1; tm[6][4] = 1'b1; // same row group, different column groups
        run("R12 2D", -1, -1);
        chk(fail && fail_idx == 4'd6, "R12", "pair caught", int'(fail_idx), 6);

        clear_tamper();
        run("R8 R9 mid-run events", 5, 7);
        chk(!fail, "R9", "mid-run start no effect", int'(fail), 0);
        run("R8 write ignored", -1, -1);
        chk(!fail, "R8", "busy write ignored", int'(fail), 0);

        load_masks(7);                         // cell 7 in no group
        tm[10][7] = 1'b1;
        run("R10 unmasked", -1, -1);
        chk(!fail, "R10", "unmasked cell ignored", int'(fail), 0);

        clear_tamper();
        load_masks(-1);
        tm[10][7] = 1'b1;
        run("R8 R10 remasked", -1, -1);
        chk(fail && fail_idx == 4'd10, "R8", "mask rewrite takes effect", int'(fail_idx), 10);

        $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
        $finish;
    end
endmodule